// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This unit works on one 16-bit word per request. It takes a data word, a control word that describes a field, and the current destination word. It then does one of five things: it pulls a field out of the data word, writes a field of the data word into the destination, or forces the destination's field bits to zero, to one, or to their inverse. The field is described by the low byte of the control word. A 4-bit size code gives the field length minus one. A 4-bit position gives the bit where the field starts.

A request is presented with `in_valid` and is always accepted. The unit has no ready signal and applies no back-pressure. The result appears in a register one clock later, marked by `out_valid`, and holds there until the next accepted request. The consumer must take every result in the cycle that `out_valid` is high. Requests may be issued on back-to-back cycles.

Top module: `bitfield_unit`

## Requirements
- R1: Only bits 7:0 of `in_ctrl` describe the field. Bits 15:8 have no effect on the result.
- R2: `in_ctrl[7:4]` is the size code S and `in_ctrl[3:0]` is the start position P. The field covers S+1 bits starting at bit P, where bit 0 is the least significant bit. S=0 selects one bit and S=15 selects sixteen bits.
- R3: Opcode 0 (extract) returns the field bits of `in_data`, right-aligned, with every result bit above the field equal to zero.
- R4: Opcode 1 (insert) copies `in_data[S:0]` into the field of `in_dest` and keeps every destination bit outside the field.
- R5: Opcode 2 (clear) returns `in_dest` with its field bits forced to 0.
- R6: Opcode 3 (set) returns `in_dest` with its field bits forced to 1.
- R7: Opcode 4 (toggle) returns `in_dest` with its field bits inverted.
- R8: When P+S+1 exceeds 16, the field stops at bit 15. Nothing wraps to the low bits, and an extract then returns only the bits from P to 15.
- R9: Opcodes 5, 6 and 7 return `in_dest` unchanged.
- R10: `out_valid` equals `in_valid` from the previous cycle. `out_result` loads only when `in_valid` is high and holds otherwise.
- R11: A synchronous reset clears `out_valid` and `out_result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present; always accepted |
| in_op | input | 3 | Operation code (0 extract, 1 insert, 2 clear, 3 set, 4 toggle) |
| in_data | input | 16 | Source data word |
| in_ctrl | input | 16 | Control word; low byte holds the field descriptor |
| in_dest | input | 16 | Current destination word |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 16 | Registered result |

## Verification
The unit keeps only a result register and a valid flag, so any fault in the decode or merge logic shows up on `out_result` in the cycle right after the request that triggers it. A fault in the field mask shows up as changed bits outside the field, or as field bits left unchanged. Clipping faults show up only when the field reaches past bit 15, so requests with high positions and large sizes are stressed on purpose. A fault in the load enable or the valid pipeline shows up during idle cycles, either as a result that drifts or as a valid pulse that is missing or extra.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int WORD_W = 16;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int DESC_W = 2 * POS_W;

  typedef enum logic [2:0] {
    OP_EXTRACT = 3'd0,
    OP_INSERT  = 3'd1,
    OP_CLEAR   = 3'd2,
    OP_SET     = 3'd3,
    OP_TOGGLE  = 3'd4
  } bfu_op_e;
endpackage

// File: rtl/bfu_field_decode.sv
module bfu_field_decode #(
  parameter int WORD_W = bfu_pkg::WORD_W,
  localparam int POS_W = $clog2(WORD_W),
  localparam int DESC_W = 2 * POS_W
) (
  input  logic [DESC_W-1:0] desc,
  output logic [POS_W-1:0]  size_code,
  output logic [POS_W-1:0]  start_pos,
  output logic [WORD_W-1:0] low_mask,
  output logic [WORD_W-1:0] field_mask
);
  assign size_code = desc[DESC_W-1:POS_W];
  assign start_pos = desc[POS_W-1:0];

  // Each bit is decided on its own. A bit past the word edge simply does not
  // exist, so clipping needs no extra logic.
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign low_mask[i]   = (32'(size_code) >= i);
    assign field_mask[i] = (i >= 32'(start_pos)) &&
                           ((i - 32'(start_pos)) <= 32'(size_code));
  end
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge #(
  parameter int WORD_W = bfu_pkg::WORD_W,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] data,
  input  logic [WORD_W-1:0] dest,
  input  logic [POS_W-1:0]  start_pos,
  input  logic [WORD_W-1:0] low_mask,
  input  logic [WORD_W-1:0] field_mask,
  output logic [WORD_W-1:0] result
);
  import bfu_pkg::*;

  logic [WORD_W-1:0] down_shifted;
  logic [WORD_W-1:0] up_shifted;

  assign down_shifted = data >> start_pos;
  assign up_shifted   = data << start_pos;

  always_comb begin
    unique case (op)
      OP_EXTRACT: result = down_shifted & low_mask;
      OP_INSERT:  result = (dest & ~field_mask) | (up_shifted & field_mask);
      OP_CLEAR:   result = dest & ~field_mask;
      OP_SET:     result = dest | field_mask;
      OP_TOGGLE:  result = dest ^ field_mask;
      default:    result = dest;
    endcase
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int WORD_W = bfu_pkg::WORD_W,
  localparam int POS_W = $clog2(WORD_W),
  localparam int DESC_W = 2 * POS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] in_ctrl,
  input  logic [WORD_W-1:0] in_dest,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result
);
  import bfu_pkg::*;

  logic [POS_W-1:0]  size_code;
  logic [POS_W-1:0]  start_pos;
  logic [WORD_W-1:0] low_mask;
  logic [WORD_W-1:0] field_mask;
  logic [WORD_W-1:0] next_result;
  logic              unused_ctrl_hi;

  // R1: the high part of the control word is deliberately dropped
  assign unused_ctrl_hi = ^in_ctrl[WORD_W-1:DESC_W];

  bfu_field_decode #(.WORD_W(WORD_W)) u_decode (
    .desc       (in_ctrl[DESC_W-1:0]),
    .size_code  (size_code),
    .start_pos  (start_pos),
    .low_mask   (low_mask),
    .field_mask (field_mask)
  );

  bfu_merge #(.WORD_W(WORD_W)) u_merge (
    .op         (in_op),
    .data       (in_data),
    .dest       (in_dest),
    .start_pos  (start_pos),
    .low_mask   (low_mask),
    .field_mask (field_mask),
    .result     (next_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_result;
    end
  end

  a_r2_field_size: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $countones(field_mask) ==
      (((32'(size_code) + 1) < (WORD_W - 32'(start_pos))) ?
        (32'(size_code) + 1) : (WORD_W - 32'(start_pos))));

  a_r3_extract_high_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_EXTRACT) |=> ((out_result & ~$past(low_mask)) == '0));

  a_r5_clear_field: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CLEAR) |=> ((out_result & $past(field_mask)) == '0));

  a_r6_set_field: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_SET) |=> ((out_result & $past(field_mask)) == $past(field_mask)));

  a_r9_spare_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > OP_TOGGLE) |=> (out_result == $past(in_dest)));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));
endmodule

// File: tb/bitfield_unit_test.sv
`timescale 1ns/1ps
module bitfield_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [15:0] in_data = '0;
  logic [15:0] in_ctrl = '0;
  logic [15:0] in_dest = '0;
  logic        out_valid;
  logic [15:0] out_result;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [15:0] last_res = '0;

  always #2.5 clk = ~clk;

  bitfield_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_dest(in_dest),
    .out_valid(out_valid), .out_result(out_result)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [15:0] model(logic [2:0] op, logic [15:0] d,
                                        logic [15:0] c, logic [15:0] t);
    int w;
    int o;
    logic [15:0] m;
    logic [15:0] r;
    w = int'(c[7:4]);
    o = int'(c[3:0]);
    m = '0;
    for (int i = 0; i < 16; i++) if (i >= o && i <= o + w) m[i] = 1'b1;
    case (op)
      3'd0: begin
        r = '0;
        for (int j = 0; j <= w; j++) if (o + j <= 15) r[j] = d[o + j];
      end
      3'd1: begin
        r = t;
        for (int i = 0; i < 16; i++) if (m[i]) r[i] = d[i - o];
      end
      3'd2: r = t & ~m;
      3'd3: r = t | m;
      3'd4: r = t ^ m;
      default: r = t;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(string tag, logic [2:0] op, logic [15:0] d,
                       logic [15:0] c, logic [15:0] t, logic [15:0] exp);
    in_valid = 1'b1; in_op = op; in_data = d; in_ctrl = c; in_dest = t;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {15'd0, out_valid}, 16'd1);
    check(tag, out_result, exp);
    last_res = exp;
  endtask

  task automatic issue_m(string tag, logic [2:0] op, logic [15:0] d,
                         logic [15:0] c, logic [15:0] t);
    issue(tag, op, d, c, t, model(op, d, c, t));
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_op = 3'($urandom); in_data = 16'($urandom);
    in_ctrl = 16'($urandom); in_dest = 16'($urandom);
    @(negedge clk);
    check("R10 idle valid", {15'd0, out_valid}, 16'd0);
    check("R10 idle hold", out_result, last_res);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 reset valid", {15'd0, out_valid}, 16'd0);
    check("R11 reset result", out_result, 16'h0000);
    rst = 1'b0;
    @(negedge clk);

    issue("R3 extract", 3'd0, 16'hABCD, 16'h0034, 16'hFFFF, 16'h000C);
    issue("R1 upper ctrl ignored", 3'd0, 16'hABCD, 16'hFF34, 16'hFFFF, 16'h000C);
    issue("R2 full width", 3'd0, 16'h1234, 16'h00F0, 16'h0000, 16'h1234);
    issue("R2 one bit", 3'd3, 16'h0000, 16'h0000, 16'h0000, 16'h0001);
    issue("R4 insert", 3'd1, 16'h0005, 16'h0021, 16'hFFFF, 16'hFFFB);
    issue("R5 clear", 3'd2, 16'h0000, 16'h0030, 16'hFFFF, 16'hFFF0);
    issue("R6 set", 3'd3, 16'h0000, 16'h0032, 16'h0000, 16'h003C);
    issue("R7 toggle", 3'd4, 16'h0000, 16'h0025, 16'h00F0, 16'h0010);
    issue("R8 clip insert", 3'd1, 16'h00FF, 16'h007C, 16'h0000, 16'hF000);
    issue("R8 clip toggle", 3'd4, 16'h0000, 16'h00FA, 16'h0000, 16'hFC00);
    issue("R8 clip extract", 3'd0, 16'h8000, 16'h00FC, 16'h0000, 16'h0008);
    issue("R9 op5", 3'd5, 16'h1111, 16'h0044, 16'h5A5A, 16'h5A5A);
    issue("R9 op7", 3'd7, 16'h1111, 16'h00FF, 16'hA5A5, 16'hA5A5);
    idle();
    idle();

    // back-to-back requests
    issue_m("R10 back-to-back", 3'd4, 16'h0, 16'h0011, 16'h0F0F);
    issue_m("R10 back-to-back", 3'd1, 16'hFFFF, 16'h0088, 16'h0000);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  op;
      logic [15:0] c;
      op = 3'($urandom);
      c = 16'($urandom);
      if (n % 4 == 0) c[3:0] = 4'hC | 4'($urandom_range(0, 3));
      case (op)
        3'd0: issue_m("R3 rand extract", op, 16'($urandom), c, 16'($urandom));
        3'd1: issue_m("R4 rand insert", op, 16'($urandom), c, 16'($urandom));
        3'd2: issue_m("R5 rand clear", op, 16'($urandom), c, 16'($urandom));
        3'd3: issue_m("R6 rand set", op, 16'($urandom), c, 16'($urandom));
        3'd4: issue_m("R7 rand toggle", op, 16'($urandom), c, 16'($urandom));
        default: issue_m("R9 rand spare", op, 16'($urandom), c, 16'($urandom));
      endcase
      if ($urandom_range(0, 3) == 0) idle();
    end

    // reset in the middle of operation
    issue("R11 pre-reset", 3'd3, 16'h0, 16'h00F0, 16'h0000, 16'hFFFF);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 mid reset valid", {15'd0, out_valid}, 16'd0);
    check("R11 mid reset result", out_result, 16'h0000);
    rst = 1'b0;
    last_res = '0;
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule